// File: doc/BRIEF.md
# Serial EEPROM Target with Page-Wrapping Writes

This block is the target side of a two-wire I2C bus and behaves like a 2048-byte serial EEPROM. It watches SCL and SDA using the system clock. It signals acknowledges and read data by pulling SDA low through an open-drain style output. The master selects the device with a control byte. That byte carries the device code 1010, three bank bits that become the top of the 11-bit address, and a read/write flag. On a write, the next byte sets the low address. Any bytes after that are page data.

Page data is collected in a 16-byte page buffer. During the burst only the low four address bits step, so a burst that runs past the end of a page wraps back to the start of the same page. When a STOP follows at least one data byte, the buffered bytes are moved into storage. A busy interval then starts, and during it the device refuses its control byte. Reads work in two ways. A read-mode control byte sent after a repeated START (a random read) returns data from the latched address. A read-mode control byte sent on its own (a current-address read) continues from wherever the last access left the counter. Reads walk the whole array and wrap from the last byte to the first.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target does not pull SDA, is not busy, and acknowledges a valid control byte straight away.
- R2: A control byte with bits 7:4 equal to 1010 is acknowledged by pulling SDA low during the ninth clock. Bit 0 set to 1 means read. In a write-mode control byte, bits 3:1 load address bits 10:8.
- R3: A control byte with any other device code gets no acknowledge. The target then leaves SDA alone for all further bytes until the next START.
- R4: The byte that follows a write-mode control byte is acknowledged and loads address bits 7:0.
- R5: Every write data byte is acknowledged and stored at the current address. After each byte only address bits 3:0 increment, so byte 17 of a page lands back at page offset 0. Bytes outside the page are left unchanged.
- R6: Written bytes reach storage after the STOP. If the transfer carried at least one data byte, a busy interval of BUSY_CYCLES clocks follows, and during it control bytes are not acknowledged. A STOP after a transfer with no data byte starts no busy interval.
- R7: After an acknowledged read-mode control byte, the target sends the byte at the current address, MSB first. The address advances by one after each byte the master acknowledges.
- R8: A master NACK ends the read burst and SDA is released. The address does not advance past the NACKed byte. A later read-mode control byte, whatever its bits 3:1, starts from that same byte.
- R9: Sequential reads carry across all 11 address bits, so a read at address 0x7FF is followed by address 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL must be much slower than this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level, already synchronised |
| sda_i | input | 1 | Bus data level as seen on the wire, already synchronised |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit), 0 releases it |

## Verification
The bench goes after the page boundary. A four-byte burst that starts two bytes before the end of a page must come back split between the page's last two bytes and its first two. A design that let the carry reach bit 4 would corrupt the first byte of the next page, which the bench has already loaded with a marker value.

Reads starting at 0x7FF must return the byte at 0x000 next; a counter that saturated or stopped at a bank edge would fail this. The busy interval is probed both inside and after its window, and also after a STOP that carried no data, so a target that always went busy or never did is caught.

A foreign device code followed by further bytes must never draw a pull on SDA. After a NACK-ended read, a current-address read must repeat the NACKed byte, which catches a counter that advanced on a NACK.

// File: rtl/eep_pkg.sv
// Package: shared state encoding and the fixed device code for the EEPROM target.
// Assumes: one target per bus; the code is compared against control-byte bits 7:4.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // off the bus until a START
        ST_CTRL,  // shifting in the control byte
        ST_ADDR,  // shifting in the low address byte
        ST_WR,    // shifting in page data
        ST_RD,    // shifting out read data
        ST_ACK,   // target holds its acknowledge for the ninth clock
        ST_MACK   // master acknowledge slot after a read byte
    } eep_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_edges.sv
// Module: bus event detector. Registers SCL and SDA once and reports SCL edges
// and the START and STOP conditions as single-cycle pulses.
// Assumes: inputs are already synchronised and each SCL phase lasts two or more clocks.
module eep_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    // Purpose: hold the previous bus levels (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i && !scl_q;
    assign scl_fall  = !scl_i && scl_q;
    assign bus_start = scl_i && scl_q && sda_q && !sda_i;
    assign bus_stop  = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/eep_store.sv
// Module: storage array, page buffer and write-busy timer.
// Collects one page of bytes with a valid mask. When commit_go arrives it copies
// the valid bytes into the array, one per clock, while the busy counter runs.
// Assumes: BUSY_CYCLES >= 2**PAGE_W, so the copy ends before busy clears.
module eep_store #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy,
    output logic                     has_data
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;
    localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [PAGE_W-1:0] ONE_P = 1;

    logic [7:0]               mem      [DEPTH];
    logic [7:0]               page_buf [PAGE_LEN];
    logic [PAGE_LEN-1:0]      vld;
    logic [CNT_W-1:0]         busy_cnt;
    logic [PAGE_W-1:0]        cidx;
    logic [ADDR_W-PAGE_W-1:0] cpage;
    logic                     committing;
    logic                     commit_done;

    assign commit_done = committing && (cidx == '1);
    assign busy        = (busy_cnt != '0);
    assign has_data    = |vld;
    assign rd_data     = mem[rd_addr];

    // Purpose: capture page bytes as they arrive.
    always_ff @(posedge clk) begin
        if (buf_we) page_buf[buf_idx] <= buf_din;
    end

    // Purpose: track which page offsets hold fresh data.
    always_ff @(posedge clk) begin
        if (!rst_n)            vld <= '0;
        else if (commit_done)  vld <= '0;
        else if (buf_clr)      vld <= '0;
        else if (buf_we)       vld[buf_idx] <= 1'b1;
    end

    // Purpose: count down the write-busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_cnt <= '0;
        else if (commit_go) busy_cnt <= CNT_W'(BUSY_CYCLES);
        else if (busy)      busy_cnt <= busy_cnt - CNT_W'(1);
    end

    // Purpose: step through the page offsets during the copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committing <= 1'b0;
            cidx       <= '0;
            cpage      <= '0;
        end else if (commit_go) begin
            committing <= 1'b1;
            cidx       <= '0;
            cpage      <= commit_page;
        end else if (committing) begin
            cidx <= cidx + ONE_P;
            if (cidx == '1) committing <= 1'b0;
        end
    end

    // Purpose: write the buffered bytes into the array (contents not reset).
    always_ff @(posedge clk) begin
        if (committing && vld[cidx]) mem[{cpage, cidx}] <= page_buf[cidx];
    end

    // R6: no new page data may arrive while the previous page is being copied
    assert_no_fill_during_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !committing)
        else $error("page buffer written during commit");

    // R6: busy counter never exceeds its programmed length
    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(BUSY_CYCLES))
        else $error("busy counter out of range");
endmodule

// File: rtl/i2c_eeprom_target.sv
// Module: top of the EEPROM target. A bit-level state machine that decodes the
// control byte, latches the address, collects page data with a 4-bit wrapping
// counter and sends sequential read data MSB first.
// Assumes: SCL is much slower than clk; SDA changes only while SCL is low,
// except for START and STOP.
module i2c_eeprom_target #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    import eep_pkg::*;

    localparam int BANK_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [PAGE_W-1:0] ONE_P = 1;

    eep_state_t               state, after_ack;
    logic [3:0]               bitcnt;
    logic [7:0]               shreg;
    logic [ADDR_W-1:0]        addr;
    logic [ADDR_W-PAGE_W-1:0] wpage;
    logic                     sda_low, mst_ack;
    logic                     scl_rise, scl_fall, bus_start, bus_stop;
    logic                     byte_done, buf_we, buf_clr, commit_go;
    logic                     busy, has_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic [7:0]               rd_data;

    eep_bus_edges edges_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign buf_we    = (state == ST_WR) && byte_done;
    assign buf_clr   = (state == ST_ADDR) && byte_done;
    assign commit_go = bus_stop && has_data && !busy;
    assign rd_addr   = (state == ST_MACK) ? addr + ONE_A : addr;

    eep_store #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_idx     (addr[PAGE_W-1:0]),
        .buf_din     (shreg),
        .commit_go   (commit_go),
        .commit_page (wpage),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .has_data    (has_data)
    );

    // Purpose: protocol state machine; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            addr      <= '0;
            wpage     <= '0;
            sda_low   <= 1'b0;
            mst_ack   <= 1'b0;
        end else if (bus_start) begin
            state   <= ST_CTRL;
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else if (bus_stop) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_CTRL, ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_CTRL) begin
                            if (shreg[7:4] == DEV_CODE && !busy) begin
                                sda_low <= 1'b1;
                                state   <= ST_ACK;
                                if (shreg[0]) begin
                                    after_ack <= ST_RD;
                                end else begin
                                    after_ack           <= ST_ADDR;
                                    addr[ADDR_W-1:8]    <= shreg[BANK_W:1];
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_ADDR) begin
                            addr[7:0] <= shreg;
                            wpage     <= {addr[ADDR_W-1:8], shreg[7:PAGE_W]};
                            sda_low   <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= ST_WR;
                        end else begin
                            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + ONE_P;
                            sda_low          <= 1'b1;
                            state            <= ST_ACK;
                            after_ack        <= ST_WR;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state  <= after_ack;
                        bitcnt <= '0;
                        if (after_ack == ST_RD) begin
                            shreg   <= rd_data;
                            sda_low <= !rd_data[7];
                        end else begin
                            sda_low <= 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_low <= 1'b0;
                            state   <= ST_MACK;
                        end else begin
                            bitcnt  <= bitcnt + 4'd1;
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= !shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mst_ack <= !sda_i;
                    end else if (scl_fall) begin
                        if (mst_ack) begin
                            addr    <= addr + ONE_A;
                            shreg   <= rd_data;
                            sda_low <= !rd_data[7];
                            bitcnt  <= '0;
                            state   <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = sda_low;

    // R3: SDA is pulled only in the acknowledge slot or while sending data
    assert_drive_only_ack_or_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> (state == ST_ACK || state == ST_RD))
        else $error("SDA pulled outside ack or data phase");

    // R5: filling the page buffer never moves the page part of the address
    assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])))
        else $error("page write crossed a page boundary");

    // R7: the address is steady while a read byte is shifted out
    assert_addr_hold_during_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |=> $stable(addr))
        else $error("address changed during a read byte");
endmodule

// File: tb/i2c_eeprom_target_tb.sv
// Bench: directed scenarios, each task drives an I2C master and checks its own results.
module i2c_eeprom_target_tb_top;
    localparam int BUSY = 200;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pull;
    wire  sda_line = m_sda & ~pull;

    always #5 clk = ~clk;

    i2c_eeprom_target #(.ADDR_W(11), .PAGE_W(4), .BUSY_CYCLES(BUSY)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  saw_pull;
    logic [7:0] wbuf [16];
    logic [7:0] rexp [16];

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) begin
            @(negedge clk);
            if (pull) saw_pull = 1'b1;
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b1; hold(Q);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(Q);
            m_scl = 1'b1; hold(Q);
            m_scl = 1'b0; hold(Q);
        end
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q / 2);
        ack = !sda_line;
        hold(Q / 2);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            m_scl = 1'b1; hold(Q);
            d[i] = sda_line;
            m_scl = 1'b0;
        end
        hold(Q);
        m_sda = !give_ack; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_scl = 1'b0; hold(Q);
        m_sda = 1'b1;
    endtask

    // Write n bytes of wbuf starting at the given control byte and low address, then STOP.
    task automatic wr(input logic [7:0] ctrl, input logic [7:0] lo, input int n, input string tag);
        bit a;
        bus_start();
        send(ctrl, a); chk({tag, " R2 control ack"}, a, 1);
        send(lo, a);   chk({tag, " R4 address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send(wbuf[i], a); chk({tag, " R5 data ack"}, a, 1);
        end
        bus_stop();
    endtask

    // Random read of n bytes, compared with rexp; the last byte is NACKed.
    task automatic rd(input logic [7:0] cw, input logic [7:0] lo, input logic [7:0] cr,
                      input int n, input string tag);
        bit a;
        logic [7:0] d;
        bus_start();
        send(cw, a); chk({tag, " R2 ctrl ack"}, a, 1);
        send(lo, a); chk({tag, " R4 addr ack"}, a, 1);
        bus_start();
        send(cr, a); chk({tag, " R2 read ctrl ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv(i != n - 1, d);
            chk({tag, " R7 read data"}, d, rexp[i]);
        end
        hold(1);
        chk({tag, " R8 SDA released after NACK"}, pull, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        bit a;
        chk("R1 SDA released after reset", pull, 0);
        bus_start();
        send(8'hA0, a); chk("R1 not busy after reset", a, 1);
        bus_stop();
    endtask

    task automatic t_basic();
        bit a;
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h81; wbuf[3] = 8'h7E;
        wr(8'hA2, 8'h23, 4, "basic");
        bus_start();
        send(8'hA2, a); chk("R6 control refused while busy", a, 0);
        bus_stop();
        hold(BUSY + 40);
        for (int i = 0; i < 4; i++) rexp[i] = wbuf[i];
        rd(8'hA2, 8'h23, 8'hA3, 4, "basic");
        bus_start();
        send(8'hA2, a); chk("R6 no busy after data-free STOP", a, 1);
        bus_stop();
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'h5A;
        wr(8'hA4, 8'h10, 1, "marker");
        hold(BUSY + 40);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        wr(8'hA4, 8'h0E, 4, "wrap");
        hold(BUSY + 40);
        rexp[0] = 8'h01; rexp[1] = 8'h02; rexp[2] = 8'h5A;
        rd(8'hA4, 8'h0E, 8'hA5, 3, "R5 wrap tail and next page untouched");
        rexp[0] = 8'h03; rexp[1] = 8'h04;
        rd(8'hA4, 8'h00, 8'hA5, 2, "R5 wrap to page start");
    endtask

    task automatic t_badcode();
        bit a;
        bus_start();
        saw_pull = 1'b0;
        send(8'hB0, a); chk("R3 foreign code not acked", a, 0);
        send(8'h00, a); chk("R3 later byte not acked", a, 0);
        send(8'hA0, a); chk("R3 code-like byte ignored mid transfer", a, 0);
        chk("R3 SDA never pulled", saw_pull, 0);
        bus_stop();
        bus_start();
        send(8'hA0, a); chk("R3 recovers at next START", a, 1);
        bus_stop();
    endtask

    task automatic t_readwrap();
        bit a;
        logic [7:0] d;
        wbuf[0] = 8'h11;
        wr(8'hAE, 8'hFF, 1, "top");
        hold(BUSY + 40);
        wbuf[0] = 8'h22;
        wr(8'hA0, 8'h00, 1, "bottom");
        hold(BUSY + 40);
        rexp[0] = 8'h11; rexp[1] = 8'h22;
        rd(8'hAE, 8'hFF, 8'hAF, 2, "R9 read wraps 7FF to 000");
        bus_start();
        send(8'hAF, a); chk("R8 current read ctrl ack", a, 1);
        recv(1'b0, d);  chk("R8 current read repeats NACKed byte", d, 8'h22);
        bus_stop();
    endtask

    task automatic t_busy_len();
        bit a;
        wbuf[0] = 8'h99;
        wr(8'hA6, 8'h40, 1, "busy");
        hold(BUSY - 150);
        bus_start();
        send(8'hA6, a); chk("R6 refused late in busy window", a, 0);
        bus_stop();
        hold(60);
        rexp[0] = 8'h99;
        rd(8'hA6, 8'h40, 8'hA7, 1, "R6 accepted after busy window");
    endtask

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(2);
        t_reset();
        t_basic();
        t_wrap();
        t_badcode();
        t_readwrap();
        t_busy_len();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule